// File: doc/BRIEF.md
# Parallel DAC Bus Controller

This block sits on the host side of a current-output DAC that has a parallel data port. That port has three parts: an active-low chip select, a read/write select line and a data bus of a parameterised width. The bus is 8, 10 or 12 bits wide, and bit 0 is the least significant bit. The controller takes single-word commands on a valid/ready port. Each command is either a write of a new code or a readback of the DAC register. The controller turns each command into one complete chip-select pulse: chip select falls, then rises again. This matters because the converter only commits a written word when chip select rises.

Every interface limit is a parameter counted in system clock cycles, rounded up from its nanosecond value. The limits are:
- the minimum low time of chip select;
- the data setup time before chip select rises;
- the delay from the read/write line going high to chip select falling;
- the minimum high time of chip select between cycles;
- the maximum read access time;
- the maximum time for the converter to release the bus after chip select rises.

The data bus is split into a driven word, an output enable and a sampled input, so the tristate buffer stays at the pad. On a readback the controller returns the sampled word. It can also flag the word when it differs from the last code the controller wrote.

Top module: `dac_par_host`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the outputs hold these values: chip select high, read/write high (1 = read), output enable low and cmd_ready high. rsp_valid is low.
- R2: A write drives read/write low, asserts the output enable and places the word on bus_dout before chip select falls. All three stay unchanged until chip select has risen. Chip select then stays low for exactly max(CS_LOW_CYC, DATA_SU_CYC) cycles, and the word that is on the bus when chip select rises is the word committed.
- R3: Chip select never stays low for fewer than CS_LOW_CYC cycles.
- R4: Before chip select falls for a readback, read/write has been high for at least RW_SU_CYC cycles.
- R5: During a readback, chip select stays low for exactly max(CS_LOW_CYC, ACCESS_CYC) cycles. rsp_data holds bus_din as it was in the last cycle before chip select rises. rsp_valid is high for one cycle, and that cycle is the one in which chip select has just risen.
- R6: Between two pulses, chip select stays high for at least CS_HIGH_CYC cycles.
- R7: The output enable is low whenever chip select is low with read/write high. After a readback, the output enable stays low for at least RELQ_CYC cycles after chip select rises.
- R8: rsp_mismatch is 1 exactly when the sampled word differs from the most recently written word. The last-written word is 0 after reset. With CMP_EN = 0 the flag is always 0.
- R9: cmd_ready is high only while no pulse is in progress. Each valid/ready handshake produces exactly one chip-select pulse.
- R10: Read/write does not change while chip select is low, and it does not change at the edge where chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_rd | input | 1 | 1 = readback, 0 = write |
| cmd_data | input | W | Word to write |
| rsp_valid | output | 1 | One-cycle pulse when readback data is ready |
| rsp_data | output | W | Sampled readback word |
| rsp_mismatch | output | 1 | Readback differs from last written word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | Read/write select, 1 = read |
| bus_oe | output | 1 | Enable for the host data driver |
| bus_dout | output | W | Word driven onto the data bus |
| bus_din | input | W | Word seen on the data bus |

## Verification
The bench models the converter. Its bus carries the inverted word until ACCESS_CYC-1 cycles after chip select falls and the true word after that. A controller that samples one cycle early therefore returns the inverted code. A controller that writes without completing the rising edge leaves the modelled register unchanged, which the next readback exposes. Other faults are caught by measuring pulse widths and the gaps between pulses:
- a shortened or lengthened low time;
- a gap between pulses that is too short;
- the output enable coming back too soon after a readback, which would mean a host driver fighting the converter.

A disturbed register is used to force the mismatch flag, and a command held on the port during a busy pulse must not produce a second pulse.

// File: rtl/dac_par_host.sv
module dac_par_host #(
  parameter int W           = 12,
  parameter int CS_LOW_CYC  = 2,
  parameter int DATA_SU_CYC = 2,
  parameter int RW_SU_CYC   = 1,
  parameter int CS_HIGH_CYC = 2,
  parameter int ACCESS_CYC  = 5,
  parameter int RELQ_CYC    = 2,
  parameter bit CMP_EN      = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_rd,
  input  logic [W-1:0] cmd_data,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data,
  output logic         rsp_mismatch,
  output logic         bus_cs_n,
  output logic         bus_rw,
  output logic         bus_oe,
  output logic [W-1:0] bus_dout,
  input  logic [W-1:0] bus_din
);

  localparam int WR_LOW  = (CS_LOW_CYC > DATA_SU_CYC) ? CS_LOW_CYC : DATA_SU_CYC;
  localparam int RD_LOW  = (CS_LOW_CYC > ACCESS_CYC) ? CS_LOW_CYC : ACCESS_CYC;
  localparam int RD_HIGH = (CS_HIGH_CYC > RELQ_CYC) ? CS_HIGH_CYC : RELQ_CYC;
  localparam int PREP    = (RW_SU_CYC > 1) ? RW_SU_CYC : 1;
  localparam int MAXL    = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int MAXH    = (RD_HIGH > PREP) ? RD_HIGH : PREP;
  localparam int MAXC    = (MAXL > MAXH) ? MAXL : MAXH;
  localparam int CW      = $clog2(MAXC + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_LOW, S_HIGH} state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic           is_rd;
  logic [W-1:0]   last_wr;

  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      cnt          <= '0;
      is_rd        <= 1'b0;
      last_wr      <= '0;
      bus_cs_n     <= 1'b1;
      bus_rw       <= 1'b1;
      bus_oe       <= 1'b0;
      bus_dout     <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_mismatch <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          is_rd  <= cmd_rd;
          bus_rw <= cmd_rd;
          bus_oe <= !cmd_rd;
          if (!cmd_rd) begin
            bus_dout <= cmd_data;
            last_wr  <= cmd_data;
          end
          cnt <= CW'(PREP - 1);
          st  <= S_PREP;
        end
        S_PREP: if (cnt == '0) begin
          bus_cs_n <= 1'b0;
          cnt      <= is_rd ? CW'(RD_LOW - 1) : CW'(WR_LOW - 1);
          st       <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt == '0) begin
          bus_cs_n <= 1'b1;
          cnt      <= is_rd ? CW'(RD_HIGH - 1) : CW'(CS_HIGH_CYC - 1);
          st       <= S_HIGH;
          if (is_rd) begin
            rsp_valid    <= 1'b1;
            rsp_data     <= bus_din;
            rsp_mismatch <= CMP_EN && (bus_din != last_wr);
          end
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt == '0) begin
          bus_rw <= 1'b1;
          bus_oe <= 1'b0;
          st     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] low_run, high_run, rwh_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= '0;
      rwh_run  <= '0;
    end else begin
      low_run  <= bus_cs_n ? '0 : ((&low_run) ? low_run : low_run + 1'b1);
      high_run <= !bus_cs_n ? '0 : ((&high_run) ? high_run : high_run + 1'b1);
      rwh_run  <= !(bus_cs_n && bus_rw) ? '0 : ((&rwh_run) ? rwh_run : rwh_run + 1'b1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> bus_cs_n && bus_rw && !bus_oe && cmd_ready && !rsp_valid); // R1
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst) !bus_cs_n && $past(!bus_cs_n) && !bus_rw |-> $stable(bus_dout) && bus_oe); // R2
  AST_CS_LOW_MIN: assert property (@(posedge clk) disable iff (rst) $rose(bus_cs_n) |-> low_run >= CW'(CS_LOW_CYC)); // R3
  AST_RW_SETUP: assert property (@(posedge clk) disable iff (rst) $fell(bus_cs_n) && bus_rw |-> rwh_run >= CW'(RW_SU_CYC)); // R4
  AST_RSP_AT_RISE: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $rose(bus_cs_n) && bus_rw); // R5
  AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (rst) $fell(bus_cs_n) |-> high_run >= CW'(CS_HIGH_CYC)); // R6
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (rst) !bus_cs_n && bus_rw |-> !bus_oe); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) cmd_ready |-> bus_cs_n); // R9
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (rst) $past(!bus_cs_n) |-> $stable(bus_rw)); // R10

endmodule

// File: tb/sim_dac_par_host.sv
module sim_dac_par_host;
  localparam int W = 12, CSL = 2, DSU = 2, RWS = 1, CSH = 2, ACC = 5, RLQ = 2;
  localparam int WR_LOW = 2, RD_LOW = 5;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_rd = 0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, rsp_mismatch, cs_n, rw, oe;
  logic [W-1:0] rsp_data, dout, din;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dac_par_host #(.W(W), .CS_LOW_CYC(CSL), .DATA_SU_CYC(DSU), .RW_SU_CYC(RWS),
    .CS_HIGH_CYC(CSH), .ACCESS_CYC(ACC), .RELQ_CYC(RLQ), .CMP_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch),
    .bus_cs_n(cs_n), .bus_rw(rw), .bus_oe(oe), .bus_dout(dout), .bus_din(din));

  // converter model
  logic [W-1:0] dac_reg = '0, cmask = '0;
  int acc_cnt = 0;
  always @(posedge clk) acc_cnt <= cs_n ? 0 : acc_cnt + 1;
  assign din = (!cs_n && rw && acc_cnt >= ACC - 1) ? (dac_reg ^ cmask) : ~(dac_reg ^ cmask);

  // monitor, sampled at the falling clock edge
  logic p_cs = 1, p_rw = 1, last_pulse_rd = 0;
  logic [W-1:0] p_dout = '0;
  int low_len = 0, last_low = 0, high_len = 0, min_high = 999, rwh = 0;
  int pulses = 0, since_rise = 1000;
  bit rws_bad = 0, contend = 0, rw_chg = 0, relq_bad = 0, rsp_bad = 0;
  always @(negedge clk) if (!rst) begin
    if (!cs_n) low_len++;
    if (cs_n) high_len++;
    if (cs_n && rw) rwh++; else rwh = 0;
    if (!cs_n && p_cs) begin
      pulses++;
      if (high_len < min_high) min_high = high_len;
      if (rw && rwh_prev < RWS) rws_bad = 1;
    end
    if (!cs_n && !p_cs && rw != p_rw) rw_chg = 1;
    if (cs_n && !p_cs) begin
      if (rw != p_rw) rw_chg = 1;
      last_low = low_len; low_len = 0; high_len = 1; since_rise = 0;
      last_pulse_rd = p_rw;
      if (!p_rw) dac_reg <= p_dout;
    end
    if (cs_n) since_rise++;
    if (!cs_n && rw && oe) contend = 1;
    if (oe && last_pulse_rd && since_rise <= RLQ) relq_bad = 1;
    if (rsp_valid && !(cs_n && !p_cs)) rsp_bad = 1;
    rwh_prev = rwh;
    p_cs = cs_n; p_rw = rw; p_dout = dout;
  end
  int rwh_prev = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(bit rd, logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_rd = rd; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (rd) while (!rsp_valid) @(negedge clk);
    else while (!cmd_ready) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 cs_n", cs_n, 1); chk("R1 rw", rw, 1); chk("R1 oe", oe, 0);
    chk("R1 ready", cmd_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_read_after_reset;
    issue(1, '0);
    chk("R5 data", rsp_data, 0); chk("R8 mismatch zero", rsp_mismatch, 0);
    chk("R5 low length", last_low, RD_LOW);
  endtask

  task automatic t_write_read(logic [W-1:0] v);
    issue(0, v);
    chk("R2 low length", last_low, WR_LOW);
    chk("R3 low min", int'(last_low >= CSL), 1);
    chk("R2 committed", dac_reg, v);
    issue(1, '0);
    chk("R5 readback", rsp_data, v); chk("R8 match", rsp_mismatch, 0);
    chk("R4 rw setup", rws_bad, 0); chk("R7 contention", contend, 0);
  endtask

  task automatic t_back_to_back;
    min_high = 999;
    issue(0, 12'h111); issue(0, 12'h222); issue(0, 12'h333);
    chk("R6 high min", int'(min_high >= CSH), 1);
    issue(1, '0);
    chk("R5 last write", rsp_data, 12'h333);
  endtask

  task automatic t_read_then_write;
    issue(1, '0); issue(0, 12'h0F0);
    chk("R7 relinquish", relq_bad, 0);
    chk("R2 committed after read", dac_reg, 12'h0F0);
  endtask

  task automatic t_mismatch;
    cmask = 12'h010;
    issue(1, '0);
    chk("R8 mismatch set", rsp_mismatch, 1);
    chk("R5 disturbed data", rsp_data, 12'h0E0);
    cmask = '0;
    issue(1, '0);
    chk("R8 mismatch clear", rsp_mismatch, 0);
  endtask

  task automatic t_busy_hold;
    int p0;
    p0 = pulses;
    @(negedge clk);
    cmd_valid = 1; cmd_rd = 0; cmd_data = 12'hA5A;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    while (cs_n) @(negedge clk);
    chk("R9 ready low while busy", cmd_ready, 0);
    cmd_valid = 0;
    repeat (12) @(negedge clk);
    #1;
    chk("R9 one pulse", pulses - p0, 1);
    chk("R10 rw stable", rw_chg, 0);
    chk("R5 rsp timing", rsp_bad, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk); rst = 0;
    #1 t_reset();
    t_read_after_reset();
    t_write_read(12'h5A3);
    t_write_read(12'hFFF);
    t_write_read(12'h000);
    t_back_to_back();
    t_read_then_write();
    t_mismatch();
    t_busy_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule